// File: doc/BRIEF.md
# Two-Level Address Translation Lookup Sequencer

This block turns the virtual address of one memory access into a physical address. It searches two translation caches, one after the other. First it searches a small, fast micro cache. If that misses, it searches a larger main cache. If both miss, it asks an external table walker for the mapping. When walking is disabled for that half of the address space, it answers with a section translation fault instead.

Each cached mapping covers one of four page sizes. A mapping is tagged with an address-space identifier and a non-secure tag, and it may be marked global. A mapping that hits is then checked against a per-domain control word and the mapping's own access-permission bits. The access either completes with a physical address and memory attributes, or it ends with an abort code.

The requester holds its request with a valid/ready pair until the answer arrives. Only one access is in flight at a time, so a request that comes during a pending walk waits. A main-cache hit copies the mapping into the micro cache. A walk result is written into both caches, and the access is then looked up again.

Top module: `addr_xlat_seq`

## Requirements
- R1: With `req_valid` high in the idle state, a micro-cache hit raises `resp_valid` after exactly one clock edge.
- R2: A micro miss followed by a main hit answers after exactly two edges. It also copies the mapping into the micro cache, so the next access to that page answers after one edge.
- R3: When both caches miss and walking is allowed, `walk_req` rises. It stays high until `walk_rsp_valid`, and no response is given while it is high. The returned mapping is written into both caches, the access completes with it, and a repeat access to that page makes no new walk.
- R4: When both caches miss, the walk-disable bit is `walk_off_lo` if `req_va < split_va` and `walk_off_hi` otherwise. If that bit is set, no walk is made and `resp_code` = 1 (section translation fault) after two edges. Addresses that are already cached still hit.
- R5: A cached mapping hits only if its non-secure tag equals `req_ns`. It must also be global, or have an ASID equal to `req_asid`.
- R6: The page size code selects how many low virtual address bits pass through untranslated: 0 gives 4 KB (12 bits), 1 gives 64 KB (16 bits), 2 gives 1 MB (20 bits), 3 gives 16 MB (24 bits). The upper bits of `resp_pa` come from the mapping's frame number, and the hit compare ignores the pass-through bits.
- R7: A mapping's domain d selects the 2-bit field `dom_ctl[2d+1:2d]`. Value 3 (manager) skips the permission check. Value 1 (client) applies R8. Value 0 or 2 gives `resp_code` = 3 (domain fault).
- R8: The permission code works as follows. 0 denies every access. 1 allows privileged accesses only. 2 allows privileged accesses and user reads. 3 allows every access. A denied access gives `resp_code` = 2.
- R9: On any nonzero `resp_code`, `resp_pa`, `resp_sec`, `resp_shr` and `resp_mtype` are all zero.
- R10: On `resp_code` = 0, `resp_sec`, `resp_shr` and `resp_mtype` equal the hit mapping's fields. For `resp_mtype`, 0 means strongly ordered, 1 means device and 2 or 3 means normal.
- R11: A one-cycle `flush` pulse invalidates every entry in both caches, so the next access must walk again.
- R12: Each cache is replaced round robin. After five different pages are walked in, the micro cache holds only the last four.
- R13: `req_ready` and `resp_valid` are high together for exactly one cycle per access, and both are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached mappings |
| req_valid | input | 1 | Access request present and held |
| req_ready | output | 1 | Request consumed (same cycle as the response) |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Current address-space identifier |
| req_ns | input | 1 | Current non-secure state |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Access is privileged |
| dom_ctl | input | 32 | Sixteen 2-bit domain controls |
| split_va | input | 32 | Boundary between the low and high walk-disable regions |
| walk_off_lo | input | 1 | Disable walks below the split |
| walk_off_hi | input | 1 | Disable walks at or above the split |
| resp_valid | output | 1 | Response valid |
| resp_code | output | 2 | 0 ok, 1 translation fault, 2 permission fault, 3 domain fault |
| resp_pa | output | 32 | Physical address |
| resp_sec | output | 1 | Secure attribute |
| resp_shr | output | 1 | Shareable attribute |
| resp_mtype | output | 2 | Memory type |
| walk_req | output | 1 | Walk request, held until answered |
| walk_va | output | 32 | Address to walk |
| walk_asid | output | 8 | ASID of the walking access |
| walk_ns | output | 1 | Security state of the walking access |
| walk_rsp_valid | input | 1 | Walk result present |
| walk_rsp_pfn | input | 20 | Frame number (upper bits of the physical address) |
| walk_rsp_size | input | 2 | Page size code |
| walk_rsp_glb | input | 1 | Mapping is global |
| walk_rsp_ap | input | 2 | Permission code |
| walk_rsp_dom | input | 4 | Domain number |
| walk_rsp_sec | input | 1 | Secure attribute |
| walk_rsp_shr | input | 1 | Shareable attribute |
| walk_rsp_mtype | input | 2 | Memory type |

## Verification
Several properties are checked on every cycle:
- every response lasts a single cycle;
- `walk_req` is held until the walker answers, and no response is given while it is high;
- a walk never starts in a region whose disable bit is set;
- a fault never carries an address or attributes;
- a flush empties both caches by the next cycle.

Other behaviour shows only in the bench's scenarios: the exact one-cycle and two-cycle latencies, ASID, global and security matching, round-robin eviction, size masking and the permission and domain decisions. The bench checks these by comparing latencies, walk counts and outputs against values it computes itself.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = VA_W - OFS_W;
  localparam int ASID_W = 8;
  localparam int DOM_W  = 4;
  localparam int NDOM   = 1 << DOM_W;

  typedef enum logic [1:0] {
    RC_OK   = 2'd0,
    RC_XLAT = 2'd1,
    RC_PERM = 2'd2,
    RC_DOM  = 2'd3
  } rc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAIN,
    ST_WALK,
    ST_DONE
  } st_e;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  pfn;
    logic [1:0]        size;
    logic              glb;
    logic [ASID_W-1:0] asid;
    logic              nsid;
    logic [1:0]        ap;
    logic [DOM_W-1:0]  dom;
    logic              sec;
    logic              shr;
    logic [1:0]        mtype;
  } ent_t;

  // Page-number bits that take part in the compare for a size code.
  function automatic logic [VPN_W-1:0] cmp_mask(input logic [1:0] sz);
    return {VPN_W{1'b1}} << {sz, 2'b00};
  endfunction

  function automatic logic [VA_W-1:0] mk_pa(input ent_t e, input logic [VA_W-1:0] va);
    logic [VPN_W-1:0] m;
    m = cmp_mask(e.size);
    return {(e.pfn & m) | (va[VA_W-1:OFS_W] & ~m), va[OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_pkg::*;
(
  input  logic [1:0]        ap,
  input  logic [DOM_W-1:0]  dom,
  input  logic              wr,
  input  logic              priv,
  input  logic [2*NDOM-1:0] dom_ctl,
  output rc_e               rc
);
  logic [1:0] dc;
  assign dc = dom_ctl[{dom, 1'b0} +: 2];

  always_comb begin
    unique case (dc)
      2'b11: rc = RC_OK;
      2'b01: begin
        unique case (ap)
          2'b00:   rc = RC_PERM;
          2'b01:   rc = priv ? RC_OK : RC_PERM;
          2'b10:   rc = (priv || !wr) ? RC_OK : RC_PERM;
          default: rc = RC_OK;
        endcase
      end
      default: rc = RC_DOM;
    endcase
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int N = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_ns,
  input  logic              wr_en,
  input  ent_t              wr_ent,
  output logic              hit,
  output ent_t              hit_ent
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  ent_t          ents [N];
  logic [N-1:0]  vld;
  logic [N-1:0]  match;
  logic [PW-1:0] rr;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = vld[i]
                   && (((ents[i].vpn ^ lk_vpn) & cmp_mask(ents[i].size)) == '0)
                   && (ents[i].nsid == lk_ns)
                   && (ents[i].glb || (ents[i].asid == lk_asid));
  end

  always_comb begin
    hit     = |match;
    hit_ent = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_ent = ents[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      rr  <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[rr] <= 1'b1;
      rr      <= (rr == LAST) ? '0 : rr + 1'b1;
    end
  end

  // Entry storage without reset; validity lives in vld.
  always_ff @(posedge clk) begin
    if (wr_en) ents[rr] <= wr_ent;
  end

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0)); // R11
endmodule

// File: rtl/addr_xlat_seq.sv
module addr_xlat_seq
  import xlat_pkg::*;
#(
  parameter int MICRO_N = 4,
  parameter int MAIN_N  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_ns,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic [2*NDOM-1:0] dom_ctl,
  input  logic [VA_W-1:0]   split_va,
  input  logic              walk_off_lo,
  input  logic              walk_off_hi,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic [VA_W-1:0]   resp_pa,
  output logic              resp_sec,
  output logic              resp_shr,
  output logic [1:0]        resp_mtype,
  output logic              walk_req,
  output logic [VA_W-1:0]   walk_va,
  output logic [ASID_W-1:0] walk_asid,
  output logic              walk_ns,
  input  logic              walk_rsp_valid,
  input  logic [VPN_W-1:0]  walk_rsp_pfn,
  input  logic [1:0]        walk_rsp_size,
  input  logic              walk_rsp_glb,
  input  logic [1:0]        walk_rsp_ap,
  input  logic [DOM_W-1:0]  walk_rsp_dom,
  input  logic              walk_rsp_sec,
  input  logic              walk_rsp_shr,
  input  logic [1:0]        walk_rsp_mtype
);
  st_e  st;
  logic u_hit, m_hit, u_wr, m_wr, walk_done, blocked;
  logic hit_now, flt_now, resp_ld, nxt_ok;
  ent_t u_ent, m_ent, u_wr_ent, walk_ent, sel_ent;
  rc_e  rc_u, rc_m, sel_rc, nxt_rc;

  assign walk_done = (st == ST_WALK) && walk_rsp_valid;
  assign blocked   = (req_va < split_va) ? walk_off_lo : walk_off_hi;

  always_comb begin
    walk_ent.vpn   = walk_va[VA_W-1:OFS_W];
    walk_ent.pfn   = walk_rsp_pfn;
    walk_ent.size  = walk_rsp_size;
    walk_ent.glb   = walk_rsp_glb;
    walk_ent.asid  = walk_asid;
    walk_ent.nsid  = walk_ns;
    walk_ent.ap    = walk_rsp_ap;
    walk_ent.dom   = walk_rsp_dom;
    walk_ent.sec   = walk_rsp_sec;
    walk_ent.shr   = walk_rsp_shr;
    walk_ent.mtype = walk_rsp_mtype;
  end

  assign u_wr     = walk_done || ((st == ST_MAIN) && m_hit);
  assign u_wr_ent = walk_done ? walk_ent : m_ent;
  assign m_wr     = walk_done;

  xlat_tlb #(.N(MICRO_N)) u_micro (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vpn(req_va[VA_W-1:OFS_W]), .lk_asid(req_asid), .lk_ns(req_ns),
    .wr_en(u_wr), .wr_ent(u_wr_ent), .hit(u_hit), .hit_ent(u_ent)
  );

  xlat_tlb #(.N(MAIN_N)) u_main (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vpn(req_va[VA_W-1:OFS_W]), .lk_asid(req_asid), .lk_ns(req_ns),
    .wr_en(m_wr), .wr_ent(walk_ent), .hit(m_hit), .hit_ent(m_ent)
  );

  xlat_perm u_perm_u (
    .ap(u_ent.ap), .dom(u_ent.dom), .wr(req_write), .priv(req_priv),
    .dom_ctl(dom_ctl), .rc(rc_u)
  );

  xlat_perm u_perm_m (
    .ap(m_ent.ap), .dom(m_ent.dom), .wr(req_write), .priv(req_priv),
    .dom_ctl(dom_ctl), .rc(rc_m)
  );

  always_comb begin
    sel_ent = (st == ST_IDLE) ? u_ent : m_ent;
    sel_rc  = (st == ST_IDLE) ? rc_u  : rc_m;
    hit_now = (st == ST_IDLE) ? (req_valid && u_hit) : ((st == ST_MAIN) && m_hit);
    flt_now = (st == ST_MAIN) && !m_hit && blocked;
    resp_ld = hit_now || flt_now;
    nxt_rc  = flt_now ? RC_XLAT : sel_rc;
    nxt_ok  = (nxt_rc == RC_OK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_code  <= RC_OK;
      resp_pa    <= '0;
      resp_sec   <= 1'b0;
      resp_shr   <= 1'b0;
      resp_mtype <= '0;
      walk_req   <= 1'b0;
      walk_va    <= '0;
      walk_asid  <= '0;
      walk_ns    <= 1'b0;
    end else begin
      resp_valid <= resp_ld;
      if (resp_ld) begin
        resp_code  <= nxt_rc;
        resp_pa    <= nxt_ok ? mk_pa(sel_ent, req_va) : '0;
        resp_sec   <= nxt_ok && sel_ent.sec;
        resp_shr   <= nxt_ok && sel_ent.shr;
        resp_mtype <= nxt_ok ? sel_ent.mtype : 2'b00;
      end
      unique case (st)
        ST_IDLE: if (req_valid) st <= u_hit ? ST_DONE : ST_MAIN;
        ST_MAIN: begin
          if (m_hit || blocked) begin
            st <= ST_DONE;
          end else begin
            st        <= ST_WALK;
            walk_req  <= 1'b1;
            walk_va   <= req_va;
            walk_asid <= req_asid;
            walk_ns   <= req_ns;
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid) begin
            walk_req <= 1'b0;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = resp_valid;

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid); // R13
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_rsp_valid) |=> walk_req); // R3
  AST_NO_RESP_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> !resp_valid); // R3
  AST_WALK_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(walk_req) |-> !((req_va < split_va) ? walk_off_lo : walk_off_hi)); // R4
  AST_FAULT_BLANK: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code != 2'd0) |-> (resp_pa == '0 && !resp_sec && !resp_shr && resp_mtype == 2'd0)); // R9
endmodule

// File: tb/sim_addr_xlat_seq.sv
module sim_addr_xlat_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic req_ns = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [31:0] dom_ctl = 32'h5555_C555;
  logic [31:0] split_va = 32'h8000_0000;
  logic walk_off_lo = 1'b0, walk_off_hi = 1'b0;
  logic resp_valid, resp_sec, resp_shr, walk_req, walk_ns;
  logic [1:0] resp_code, resp_mtype;
  logic [31:0] resp_pa, walk_va;
  logic [7:0] walk_asid;
  logic walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_pfn = '0;
  logic [1:0] walk_rsp_size = '0, walk_rsp_ap = '0, walk_rsp_mtype = '0;
  logic walk_rsp_glb = 1'b0, walk_rsp_sec = 1'b0, walk_rsp_shr = 1'b0;
  logic [3:0] walk_rsp_dom = '0;

  int n_tests = 0, n_fail = 0, n_walks = 0;
  int g_lat;
  logic [1:0] g_code, g_mt;
  logic [31:0] g_pa;
  logic g_sec, g_shr;

  always #5 clk = ~clk;

  addr_xlat_seq u0 (.*);

  // Page table model: every field follows from address bits 31:24.
  function automatic logic [31:0] exp_pa(logic [31:0] va);
    logic [31:0] keep;
    keep = 32'hFFFF_FFFF << (12 + 4 * int'(va[31:30]));
    return ({va[31:12] ^ 20'h5A3C7, 12'h000} & keep) | (va & ~keep);
  endfunction

  function automatic logic [1:0] exp_rc(logic [31:0] va, logic wr, logic pv, logic [31:0] dc);
    int d;
    logic [1:0] f, ap;
    d  = int'(va[26:24]);
    f  = dc[2*d +: 2];
    ap = va[28:27];
    if (f == 2'b11) return 2'd0;
    if (f != 2'b01) return 2'd3;
    if (ap == 2'd3) return 2'd0;
    if (ap == 2'd2) return (pv || !wr) ? 2'd0 : 2'd2;
    if (ap == 2'd1) return pv ? 2'd0 : 2'd2;
    return 2'd2;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Walker model: answers three cycles after seeing a request.
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (walk_rsp_valid) begin
        walk_rsp_valid = 1'b0;
      end else if (walk_req) begin
        wcnt++;
        if (wcnt == 3) begin
          wcnt           = 0;
          n_walks++;
          walk_rsp_pfn   = walk_va[31:12] ^ 20'h5A3C7;
          walk_rsp_size  = walk_va[31:30];
          walk_rsp_glb   = walk_va[29];
          walk_rsp_ap    = walk_va[28:27];
          walk_rsp_dom   = {1'b0, walk_va[26:24]};
          walk_rsp_sec   = ~walk_ns;
          walk_rsp_shr   = walk_va[29] ^ walk_va[24];
          walk_rsp_mtype = {walk_va[25], walk_va[28]};
          walk_rsp_valid = 1'b1;
        end
      end
    end
  end

  task automatic access(input logic [31:0] va, input logic [7:0] asid, input logic ns,
                        input logic wr, input logic pv);
    @(negedge clk);
    req_va = va; req_asid = asid; req_ns = ns; req_write = wr; req_priv = pv;
    req_valid = 1'b1;
    g_lat = 0;
    do begin
      @(negedge clk);
      g_lat++;
    end while (!resp_valid && g_lat < 60);
    chk(req_ready == resp_valid, "R13 ready with response", 32'(req_ready), 32'(resp_valid));
    g_code = resp_code; g_pa = resp_pa; g_sec = resp_sec; g_shr = resp_shr; g_mt = resp_mtype;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!resp_valid, "R13 single-cycle response", 32'(resp_valid), 32'd0);
  endtask

  task automatic check_result(input string tag, input logic [31:0] va, input logic ns,
                              input logic wr, input logic pv);
    logic [1:0] rc;
    logic ok;
    rc = exp_rc(va, wr, pv, dom_ctl);
    ok = (rc == 2'd0);
    chk(g_code == rc, {tag, " code"}, 32'(g_code), 32'(rc));
    chk(g_pa == (ok ? exp_pa(va) : 32'h0), {tag, " R6 pa"}, g_pa, ok ? exp_pa(va) : 32'h0);
    chk({g_sec, g_shr, g_mt} == (ok ? {~ns, va[29] ^ va[24], va[25], va[28]} : 4'b0),
        {tag, " R10 attributes"}, 32'({g_sec, g_shr, g_mt}),
        32'(ok ? {~ns, va[29] ^ va[24], va[25], va[28]} : 4'b0));
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!resp_valid && !req_ready && !walk_req, "R13 reset state",
        32'({resp_valid, req_ready, walk_req}), 32'd0);

    // R3 walk then R1 micro hit
    w0 = n_walks;
    access(32'h1B00_3123, 8'd1, 1'b0, 1'b1, 1'b0);
    chk(n_walks == w0 + 1, "R3 walk on double miss", 32'(n_walks - w0), 32'd1);
    check_result("R3 walked result", 32'h1B00_3123, 1'b0, 1'b1, 1'b0);
    access(32'h1B00_3FF0, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_lat == 1, "R1 micro hit latency", 32'(g_lat), 32'd1);
    chk(n_walks == w0 + 1, "R3 no second walk", 32'(n_walks - w0), 32'd1);
    check_result("R1 micro hit", 32'h1B00_3FF0, 1'b0, 1'b0, 1'b0);

    // R5 matching
    w0 = n_walks;
    access(32'h1B00_3123, 8'd2, 1'b0, 1'b0, 1'b0);
    chk(n_walks == w0 + 1, "R5 other ASID misses", 32'(n_walks - w0), 32'd1);
    access(32'h1B00_3123, 8'd1, 1'b1, 1'b0, 1'b0);
    chk(n_walks == w0 + 2, "R5 other security state misses", 32'(n_walks - w0), 32'd2);
    check_result("R5 ns mapping", 32'h1B00_3123, 1'b1, 1'b0, 1'b0);
    access(32'h3B00_5000, 8'd1, 1'b0, 1'b0, 1'b0);
    access(32'h3B00_5004, 8'd9, 1'b0, 1'b0, 1'b0);
    chk(n_walks == w0 + 3 && g_lat == 1, "R5 global hits any ASID", 32'(g_lat), 32'd1);

    // R6 sizes
    access(32'hDB12_3456, 8'd1, 1'b0, 1'b0, 1'b0);
    check_result("R6 16MB walked", 32'hDB12_3456, 1'b0, 1'b0, 1'b0);
    access(32'hDBF0_0008, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_lat == 1, "R6 16MB entry covers offset", 32'(g_lat), 32'd1);
    check_result("R6 16MB", 32'hDBF0_0008, 1'b0, 1'b0, 1'b0);
    access(32'h5B01_2345, 8'd1, 1'b0, 1'b0, 1'b0);
    access(32'h5B01_FFFC, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_lat == 1, "R6 64KB entry covers offset", 32'(g_lat), 32'd1);
    check_result("R6 64KB", 32'h5B01_FFFC, 1'b0, 1'b0, 1'b0);

    // R8 permissions, R7 domains, R9 blank faults
    access(32'h0B00_0000, 8'd1, 1'b0, 1'b0, 1'b0);
    check_result("R8 priv-only user read", 32'h0B00_0000, 1'b0, 1'b0, 1'b0);
    access(32'h0B00_0000, 8'd1, 1'b0, 1'b1, 1'b1);
    check_result("R8 priv-only priv write", 32'h0B00_0000, 1'b0, 1'b1, 1'b1);
    access(32'h1300_0000, 8'd1, 1'b0, 1'b1, 1'b0);
    check_result("R8 user-ro write", 32'h1300_0000, 1'b0, 1'b1, 1'b0);
    access(32'h1300_0000, 8'd1, 1'b0, 1'b0, 1'b0);
    check_result("R8 user-ro read", 32'h1300_0000, 1'b0, 1'b0, 1'b0);
    access(32'h0300_0000, 8'd1, 1'b0, 1'b0, 1'b1);
    check_result("R8 no access", 32'h0300_0000, 1'b0, 1'b0, 1'b1);
    access(32'h1E00_0000, 8'd1, 1'b0, 1'b0, 1'b1);
    chk(g_code == 2'd3, "R7 domain no access", 32'(g_code), 32'd3);
    check_result("R9 domain fault blank", 32'h1E00_0000, 1'b0, 1'b0, 1'b1);
    access(32'h0700_0000, 8'd1, 1'b0, 1'b1, 1'b0);
    chk(g_code == 2'd0, "R7 manager skips check", 32'(g_code), 32'd0);

    // R11 flush
    w0 = n_walks;
    access(32'h1B00_3123, 8'd1, 1'b0, 1'b0, 1'b0);
    do_flush();
    access(32'h1B00_3123, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(n_walks == w0 + 1, "R11 flush forces walk", 32'(n_walks - w0), 32'd1);

    // R4 walk gating
    do_flush();
    walk_off_lo = 1'b1;
    w0 = n_walks;
    access(32'h1B00_7000, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_code == 2'd1 && g_lat == 2, "R4 low region fault", 32'({g_code, 8'(g_lat)}), 32'h102);
    chk(n_walks == w0, "R4 no walk when disabled", 32'(n_walks - w0), 32'd0);
    chk(g_pa == 32'h0, "R9 translation fault blank", g_pa, 32'h0);
    access(32'h9B00_0040, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(n_walks == w0 + 1, "R4 high region walks", 32'(n_walks - w0), 32'd1);
    check_result("R4 high region", 32'h9B00_0040, 1'b0, 1'b0, 1'b0);
    walk_off_hi = 1'b1;
    access(32'h9B0F_0000, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_code == 2'd0 && g_lat == 1, "R4 cached still hits", 32'(g_code), 32'd0);
    access(32'h9B40_0000, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_code == 2'd1, "R4 high region fault", 32'(g_code), 32'd1);
    walk_off_lo = 1'b0; walk_off_hi = 1'b0;

    // R12 round robin, R2 main hit and micro refill
    do_flush();
    for (int k = 0; k < 5; k++) access(32'h1B00_0000 + 32'(k) * 32'h1000, 8'd1, 1'b0, 1'b0, 1'b0);
    access(32'h1B00_4000, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_lat == 1, "R12 newest page in micro", 32'(g_lat), 32'd1);
    w0 = n_walks;
    access(32'h1B00_0010, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_lat == 2, "R12 R2 evicted page hits main", 32'(g_lat), 32'd2);
    chk(n_walks == w0, "R2 main hit no walk", 32'(n_walks - w0), 32'd0);
    check_result("R2 main hit", 32'h1B00_0010, 1'b0, 1'b0, 1'b0);
    access(32'h1B00_0020, 8'd1, 1'b0, 1'b0, 1'b0);
    chk(g_lat == 1, "R2 micro refilled", 32'(g_lat), 32'd1);

    // Constrained random mix
    begin
      logic [7:0] tops [12];
      for (int i = 0; i < 12; i++) tops[i] = 8'($urandom);
      dom_ctl = $urandom;
      for (int n = 0; n < 400; n++) begin
        logic [31:0] va;
        logic ns, wr, pv;
        va = {tops[$urandom_range(0, 11)], 4'($urandom_range(0, 2)), 4'($urandom_range(0, 1)),
              4'($urandom_range(0, 1)), 12'($urandom)};
        ns = 1'($urandom); wr = 1'($urandom); pv = 1'($urandom);
        if ($urandom_range(0, 39) == 0) do_flush();
        access(va, 8'($urandom_range(1, 2)), ns, wr, pv);
        check_result("R7 R8 R10 random", va, ns, wr, pv);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule